// File: doc/BRIEF.md
# Late-Write Memory Controller with Byte Bypass

This block wraps a synchronous single-port storage array behind a clocked command bus that uses a late-write protocol. A write command carries the address and the per-lane enables. Its data arrives one cycle later. Because of this, a bus that switches from reading to writing needs no idle turnaround cycle. The block does not write the array at once. It parks each completed write in a holding entry and commits that entry to the array during the data phase of the next write. Any number of reads may come in between, and the entry stays parked through them.

Every read is compared against the write whose data is arriving now and against the parked entry. Lanes that either of them wrote are forwarded in place of the array contents. Lanes they did not write come from the array, so a read always returns the most recent data. Read data is registered and presented in the cycle after the command, together with an output-enable for an external tri-state driver. A synchronous sleep input stops the block. While it is high the output enable is forced low and commands are refused. When it drops, a recovery interval of a set number of cycles must pass before the ready output rises again. Stored contents, including a parked write, survive sleep.

The command path has one form of back-pressure, the `ready` output. A command presented while `ready` is low is dropped and has no effect, and the requester must present it again. Write data has no handshake. It must be valid in the cycle after an accepted write command, even if sleep begins in that cycle.

Top module: `lw_sram_ctrl`

## Requirements
- R1: A write command is accepted when `cmd_en`=1, `cmd_we`=1 and `ready`=1. `cmd_addr` and `cmd_be` are taken in that cycle. `wr_data` is taken in the following cycle. Lane i is bits [9i+8:9i], and its enable is `cmd_be[i]`.
- R2: A read of an address returns that address's newest written data. This holds even when the read is issued in the cycle right after the write command, while the write's data is still arriving.
- R3: Forwarding is per lane. After a write with only some enable bits set, a read returns the new value in the enabled lanes and the previous content in every other lane.
- R4: A read command accepted in cycle c (`cmd_en`=1, `cmd_we`=0, `ready`=1) puts its data on `rd_data` with `rd_oe`=1 in cycle c+1, unless `sleep_req` is high in cycle c. `rd_oe` is 1 only in the cycle after an accepted read.
- R5: `rd_oe` is 0 in the cycle after an accepted write command and in the cycle after any cycle with no accepted read.
- R6: Writes take effect in command order. The parked entry changes only in a write data phase. When consecutive writes target the same address, the earlier one is committed first, so overlapping lanes end with the later value and the other lanes keep the earlier value.
- R7: After reset, `ready`=1 and `rd_oe`=0, and the parked entry is empty. A write whose data was parked but not yet committed when reset was asserted is discarded: it is never forwarded and never written to the array.
- R8: `sleep_req` is sampled at the clock edge. From the next cycle onward, while it stays high, `ready`=0 and `rd_oe`=0, and commands have no effect on stored data or outputs.
- R9: Once `sleep_req` is seen low at an edge after a sleep, `ready` stays 0 for exactly WAKE_CYCLES further cycles and then rises. All stored contents are unchanged, including a write that was parked before sleep.
- R10: Commands issued during the recovery interval are ignored in the same way as commands issued during sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all activity on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_en | input | 1 | Command present this cycle |
| cmd_we | input | 1 | 1 = write command, 0 = read command |
| cmd_addr | input | ADDR_W | Word address of the command |
| cmd_be | input | LANES | Per-lane write enables, taken with a write command |
| wr_data | input | LANES*LANE_W | Write data, taken the cycle after a write command |
| sleep_req | input | 1 | Synchronous sleep request |
| ready | output | 1 | Commands are accepted this cycle |
| rd_data | output | LANES*LANE_W | Registered read data |
| rd_oe | output | 1 | Enable for the external data-bus driver; `rd_data` is valid |

## Verification
The bench builds the block with ADDR_W=3, two 9-bit lanes and WAKE_CYCLES=3. With only eight words, every address can be written and read back, and every address can be swept through all four lane-enable patterns, so each forwarding case is reached: from the arriving write, from the parked entry, and from both at once. The short recovery window lets the bench count the ready-low cycles exactly and place ignored commands inside that window. A pseudo-random mix of back-to-back reads and writes then hits same-address write chains and commits to an address that is being read at the time.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  // Power-state encoding of the sleep sequencer
  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'd0,
    PWR_SLEEP  = 2'd1,
    PWR_WAKE   = 2'd2
  } pwr_state_e;

  // Lane select helper: the lane that wins for a read
  typedef enum logic [1:0] {
    SRC_ARRAY = 2'd0,
    SRC_HOLD  = 2'd1,
    SRC_LIVE  = 2'd2
  } lane_src_e;

endpackage

// File: rtl/lw_hold_buffer.sv
// Two-stage write path: the command stage waits for its data,
// then the completed write is parked until the next data phase.
module lw_hold_buffer #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_fire,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [LANES-1:0]        cmd_be,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic                    stage_valid,
  output logic [ADDR_W-1:0]       stage_addr,
  output logic [LANES-1:0]        stage_be,
  output logic                    hold_valid,
  output logic [ADDR_W-1:0]       hold_addr,
  output logic [LANES-1:0]        hold_be,
  output logic [LANES*LANE_W-1:0] hold_data,
  output logic                    commit_en
);

  localparam int DATA_W = LANES * LANE_W;

  // Control flags carry a reset; payload registers do not need one
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_valid <= 1'b0;
      hold_valid  <= 1'b0;
    end else begin
      stage_valid <= wr_fire;
      if (stage_valid) begin
        hold_valid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      stage_addr <= cmd_addr;
      stage_be   <= cmd_be;
    end
    if (stage_valid) begin
      hold_addr <= stage_addr;
      hold_be   <= stage_be;
      hold_data <= wr_data[DATA_W-1:0];
    end
  end

  // The parked entry drains exactly when a newer write completes
  assign commit_en = stage_valid && hold_valid;

endmodule

// File: rtl/lw_storage_array.sv
// Lane-sliced storage: each lane is its own memory with its own enable.
module lw_storage_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_be,
  input  logic [LANES*LANE_W-1:0] wr_word,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_word
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_be[l]) begin
        cells[wr_addr] <= wr_word[l*LANE_W +: LANE_W];
      end
    end

    assign rd_word[l*LANE_W +: LANE_W] = cells[rd_addr];
  end

endmodule

// File: rtl/lw_read_merge.sv
// Per-lane source selection for reads and the registered read port.
module lw_read_merge
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_fire,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [LANES*LANE_W-1:0] array_word,
  input  logic                    stage_valid,
  input  logic [ADDR_W-1:0]       stage_addr,
  input  logic [LANES-1:0]        stage_be,
  input  logic [LANES*LANE_W-1:0] live_data,
  input  logic                    hold_valid,
  input  logic [ADDR_W-1:0]       hold_addr,
  input  logic [LANES-1:0]        hold_be,
  input  logic [LANES*LANE_W-1:0] hold_data,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_pend
);

  localparam int DATA_W = LANES * LANE_W;

  logic              live_hit;
  logic              hold_hit;
  logic [DATA_W-1:0] merged;

  assign live_hit = stage_valid && (stage_addr == rd_addr);
  assign hold_hit = hold_valid  && (hold_addr  == rd_addr);

  // The arriving write is newer than the parked one, which is newer
  // than the array, so the lane source follows that priority.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lane_src_e src;

    always_comb begin
      if (live_hit && stage_be[l]) begin
        src = SRC_LIVE;
      end else if (hold_hit && hold_be[l]) begin
        src = SRC_HOLD;
      end else begin
        src = SRC_ARRAY;
      end
    end

    always_comb begin
      case (src)
        SRC_LIVE: merged[l*LANE_W +: LANE_W] = live_data[l*LANE_W +: LANE_W];
        SRC_HOLD: merged[l*LANE_W +: LANE_W] = hold_data[l*LANE_W +: LANE_W];
        default:  merged[l*LANE_W +: LANE_W] = array_word[l*LANE_W +: LANE_W];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
    end else begin
      rd_pend <= rd_fire;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_fire) begin
      rd_data <= merged;
    end
  end

endmodule

// File: rtl/lw_sleep_ctrl.sv
// Sleep sequencer: sleep, then a counted recovery before commands resume.
module lw_sleep_ctrl
  import lw_sram_pkg::*;
#(
  parameter int WAKE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  output logic ready
);

  localparam int CNT_W = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_CYCLES - 1);

  pwr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      PWR_ACTIVE: begin
        if (sleep_req) state_d = PWR_SLEEP;
      end
      PWR_SLEEP: begin
        if (!sleep_req) begin
          state_d = PWR_WAKE;
          cnt_d   = '0;
        end
      end
      PWR_WAKE: begin
        if (sleep_req) begin
          state_d = PWR_SLEEP;
        end else if (cnt_q == CNT_LAST) begin
          state_d = PWR_ACTIVE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = PWR_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PWR_ACTIVE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ready = (state_q == PWR_ACTIVE);

endmodule

// File: rtl/lw_sram_ctrl.sv
// Late-write memory controller with per-lane read bypass.
module lw_sram_ctrl #(
  parameter int ADDR_W      = 8,
  parameter int LANES       = 2,
  parameter int LANE_W      = 9,
  parameter int WAKE_CYCLES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_en,
  input  logic                    cmd_we,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [LANES-1:0]        cmd_be,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic                    sleep_req,
  output logic                    ready,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_oe
);

  localparam int DATA_W = LANES * LANE_W;

  logic              wr_fire;
  logic              rd_fire;
  logic              stage_valid;
  logic [ADDR_W-1:0] stage_addr;
  logic [LANES-1:0]  stage_be;
  logic              hold_valid;
  logic [ADDR_W-1:0] hold_addr;
  logic [LANES-1:0]  hold_be;
  logic [DATA_W-1:0] hold_data;
  logic              commit_en;
  logic [DATA_W-1:0] array_word;
  logic              rd_pend;

  assign wr_fire = cmd_en && ready &&  cmd_we;
  assign rd_fire = cmd_en && ready && !cmd_we;

  lw_sleep_ctrl #(
    .WAKE_CYCLES(WAKE_CYCLES)
  ) i_sleep (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .ready     (ready)
  );

  lw_hold_buffer #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) i_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_fire     (wr_fire),
    .cmd_addr    (cmd_addr),
    .cmd_be      (cmd_be),
    .wr_data     (wr_data),
    .stage_valid (stage_valid),
    .stage_addr  (stage_addr),
    .stage_be    (stage_be),
    .hold_valid  (hold_valid),
    .hold_addr   (hold_addr),
    .hold_be     (hold_be),
    .hold_data   (hold_data),
    .commit_en   (commit_en)
  );

  lw_storage_array #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) i_array (
    .clk     (clk),
    .wr_en   (commit_en),
    .wr_addr (hold_addr),
    .wr_be   (hold_be),
    .wr_word (hold_data),
    .rd_addr (cmd_addr),
    .rd_word (array_word)
  );

  lw_read_merge #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) i_merge (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_fire     (rd_fire),
    .rd_addr     (cmd_addr),
    .array_word  (array_word),
    .stage_valid (stage_valid),
    .stage_addr  (stage_addr),
    .stage_be    (stage_be),
    .live_data   (wr_data),
    .hold_valid  (hold_valid),
    .hold_addr   (hold_addr),
    .hold_be     (hold_be),
    .hold_data   (hold_data),
    .rd_data     (rd_data),
    .rd_pend     (rd_pend)
  );

  // The bus driver is released whenever the block is asleep or recovering
  assign rd_oe = rd_pend && ready;

endmodule

// File: rtl/lw_sram_ctrl_chk.sv
module lw_sram_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_en,
  input logic              cmd_we,
  input logic              sleep_req,
  input logic              ready,
  input logic              rd_oe,
  input logic              stage_valid,
  input logic [ADDR_W-1:0] hold_addr
);

  AST_DATA_PHASE_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    stage_valid |-> $past(cmd_en && cmd_we && ready)); // R1

  AST_READ_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && !cmd_we && ready && !sleep_req) |=> rd_oe); // R4

  AST_WRITE_QUIETS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && cmd_we && ready) |=> !rd_oe); // R5

  AST_HOLD_MOVES_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_valid |=> $stable(hold_addr)); // R6

  AST_SLEEP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> (!ready && !rd_oe)); // R8

  AST_WAKE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(!sleep_req)); // R9

endmodule

bind lw_sram_ctrl lw_sram_ctrl_chk #(
  .ADDR_W(ADDR_W)
) i_lw_sram_ctrl_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_en      (cmd_en),
  .cmd_we      (cmd_we),
  .sleep_req   (sleep_req),
  .ready       (ready),
  .rd_oe       (rd_oe),
  .stage_valid (stage_valid),
  .hold_addr   (hold_addr)
);

// File: tb/test_lw_sram_ctrl.sv
`timescale 1ns/1ps
module test_lw_sram_ctrl;

  localparam int AW    = 3;
  localparam int LN    = 2;
  localparam int LW    = 9;
  localparam int DW    = LN * LW;
  localparam int WK    = 3;
  localparam int DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          cmd_en;
  logic          cmd_we;
  logic [AW-1:0] cmd_addr;
  logic [LN-1:0] cmd_be;
  logic [DW-1:0] wr_data;
  logic          sleep_req;
  logic          ready;
  logic [DW-1:0] rd_data;
  logic          rd_oe;

  lw_sram_ctrl #(
    .ADDR_W(AW), .LANES(LN), .LANE_W(LW), .WAKE_CYCLES(WK)
  ) i_lw_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_we(cmd_we),
    .cmd_addr(cmd_addr), .cmd_be(cmd_be), .wr_data(wr_data),
    .sleep_req(sleep_req), .ready(ready), .rd_data(rd_data), .rd_oe(rd_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  logic [DW-1:0] ref_mem [DEPTH];
  int            n_run  = 0;
  int            n_fail = 0;
  bit            exp_oe = 0;
  logic [DW-1:0] exp_q  = '0;
  string         exp_tag = "R5";
  bit            pend = 0;
  logic [DW-1:0] pend_data = '0;
  int            mst = 0;   // 0 active, 1 asleep, 2 recovering
  int            mcnt = 0;
  logic [15:0]   lf = 16'hACE1;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'((a * 5281 + k * 977 + 3) % (1 << DW));
  endfunction

  // One bus cycle: check outputs of the previous cycle, then drive this one
  task automatic step(input bit en, input bit we, input int addr,
                      input logic [LN-1:0] be, input logic [DW-1:0] data,
                      input bit slp, input string tag);
    bit acc;
    @(negedge clk);
    chk(rd_oe == exp_oe, {exp_tag, " rd_oe"}, 32'(rd_oe), 32'(exp_oe));
    if (exp_oe) chk(rd_data == exp_q, {exp_tag, " rd_data"}, 32'(rd_data), 32'(exp_q));
    chk(ready == (mst == 0), "R9 ready", 32'(ready), 32'(mst == 0));
    cmd_en    = en;
    cmd_we    = we;
    cmd_addr  = AW'(addr);
    cmd_be    = be;
    wr_data   = pend ? pend_data : pat(addr + 11, 7);
    sleep_req = slp;
    acc       = en && (mst == 0);
    pend      = acc && we;
    pend_data = data;
    if (acc && we)
      for (int l = 0; l < LN; l++)
        if (be[l]) ref_mem[addr][l*LW +: LW] = data[l*LW +: LW];
    exp_oe  = acc && !we && !slp;
    exp_tag = tag;
    if (exp_oe) exp_q = ref_mem[addr];
    if (slp) mst = 1;
    else if (mst == 1) begin mst = 2; mcnt = 0; end
    else if (mst == 2) begin
      if (mcnt == WK - 1) mst = 0; else mcnt++;
    end
  endtask

  task automatic wr(input int a, input logic [LN-1:0] be, input logic [DW-1:0] d, input string tag);
    step(1, 1, a, be, d, 0, tag);
  endtask
  task automatic rd(input int a, input string tag);
    step(1, 0, a, '0, '0, 0, tag);
  endtask
  task automatic idle(input string tag);
    step(0, 0, 0, '0, '0, 0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_en = 1'b0; sleep_req = 1'b0;
    repeat (2) @(negedge clk);
    chk(rd_oe == 1'b0, "R7 rd_oe in reset", 32'(rd_oe), 32'd0);
    rst_n = 1'b1;
    pend = 0; exp_oe = 0; exp_tag = "R7"; mst = 0;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] saved;
    rst_n = 1'b0; cmd_en = 0; cmd_we = 0; cmd_addr = '0; cmd_be = '0;
    wr_data = '0; sleep_req = 0;
    for (int a = 0; a < DEPTH; a++) ref_mem[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R7 ready after reset", 32'(ready), 32'd1);
    chk(rd_oe == 1'b0, "R7 rd_oe after reset", 32'(rd_oe), 32'd0);

    // R1: fill every word with full-width writes, back to back
    for (int a = 0; a < DEPTH; a++) wr(a, 2'b11, pat(a, 1), "R1");
    idle("R5");
    for (int a = 0; a < DEPTH; a++) rd(a, "R2 readback");

    // R2: read straight after the write command (data still arriving)
    for (int a = 0; a < DEPTH; a++) begin
      wr(a, 2'b11, pat(a, 2), "R5");
      rd(a, "R2 live forward");
      rd(a, "R2 parked forward");
    end

    // R3: every lane-enable pattern at every address
    for (int a = 0; a < DEPTH; a++)
      for (int b = 0; b < 4; b++) begin
        wr(a, LN'(b), pat(a, 10 + b), "R5");
        rd(a, "R3 lane merge");
        rd((a + 1) % DEPTH, "R3 other word");
      end

    // R6: same-address chains with overlapping lanes
    for (int a = 0; a < DEPTH; a++) begin
      wr(a, 2'b01, pat(a, 20), "R5");
      wr(a, 2'b10, pat(a, 21), "R5");
      wr(a, 2'b01, pat(a, 22), "R5");
      rd(a, "R6 write order");
      wr((a + 3) % DEPTH, 2'b11, pat(a, 23), "R5");
      idle("R5");
      rd(a, "R6 after commit");
    end

    // R6: pseudo-random mix of reads, writes and idles
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (lf[1:0])
        2'd0, 2'd1: wr(int'(lf[4:2]), lf[6:5], pat(int'(lf[4:2]), int'(lf[15:7])), "R5");
        2'd2:       rd(int'(lf[4:2]), "R6 mixed traffic");
        default:    idle("R5");
      endcase
    end
    idle("R5");

    // R7: parked write discarded by reset
    saved = ref_mem[5];
    wr(5, 2'b11, pat(5, 99), "R5");
    idle("R5");
    do_reset();
    ref_mem[5] = saved;
    wr(2, 2'b11, pat(2, 98), "R7");
    idle("R7");
    rd(5, "R7 stale write dropped");
    rd(2, "R7 post-reset write");

    // R8/R9/R10: sleep, ignored commands, counted recovery
    wr(1, 2'b10, pat(1, 50), "R5");
    idle("R5");
    step(0, 0, 0, '0, '0, 1, "R8");
    step(1, 1, 0, 2'b11, pat(0, 51), 1, "R8 write asleep");
    step(1, 0, 1, '0, '0, 1, "R8 read asleep");
    step(0, 0, 0, '0, '0, 1, "R8");
    step(1, 1, 3, 2'b11, pat(3, 52), 0, "R10 write waking");
    step(1, 0, 3, '0, '0, 0, "R10 read waking");
    step(1, 1, 4, 2'b01, pat(4, 53), 0, "R10 write waking");
    idle("R10");
    for (int a = 0; a < DEPTH; a++) rd(a, "R9 contents kept");
    // sleep raised in the data phase of a write; data still taken
    wr(6, 2'b11, pat(6, 60), "R5");
    step(0, 0, 0, '0, '0, 1, "R8");
    step(0, 0, 0, '0, '0, 0, "R9");
    for (int i = 0; i < WK + 1; i++) idle("R9");
    rd(6, "R9 write across sleep");
    idle("R4");
    idle("R5");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule